// File: doc/BRIEF.md
# Muon Segment Pair Compatibility Checker

This block judges whether two track segments, measured at two different detector stations, could belong to one particle that came from the collision point. Each segment carries an azimuth coordinate, a local bend angle in azimuth, a pseudorapidity coordinate and a segment quality code. Two road checks run side by side. The pseudorapidity road tests where the segments sit and how far apart they are. The azimuth road tests the azimuth difference against a limit that depends on the track's pseudorapidity window, and against the bend angle measured at each station.

When both roads pass, the block grades the pair from the weaker of the two segment qualities. When either road fails, the grade is zero. The grade and a valid strobe are registered and appear one clock after the input strobe. All limits sit in a small register file loaded through an address/data write port. The block runs at one pair per clock.

Top module: `seg_pair_chk`

## Requirements
- R1: `out_vld` equals `in_vld` delayed by one clock. Whenever `out_vld` is low, `out_qual` is 0.
- R2: Both `eta_a` and `eta_b` must lie in the inclusive range [lower bound, upper bound]. The lower bound is loaded at address 0 and the upper bound at address 1, each from data bits [6:0].
- R3: The unsigned gap |eta_b - eta_a| must not exceed the span limit loaded at address 2, data bits [6:0].
- R4: The azimuth difference is (phi_b - phi_a) modulo 4096, read as a 12-bit two's-complement number, so pairs that straddle the wrap point give small differences. Its magnitude must not exceed the limit of the selected window.
- R5: The window index is the number of the three thresholds (addresses 3, 4 and 5, data [6:0]) that are less than or equal to `eta_a`. The per-window limits are 6 bits each: window 0 in address 6 [5:0], window 1 in address 6 [11:6], window 2 in address 7 [5:0], window 3 in address 7 [11:6].
- R6: Each 5-bit two's-complement bend must have the same sign as the azimuth difference. Negative means below zero, so zero counts as non-negative.
- R7: At each station, the gap between |azimuth difference| and |bend| must not exceed the tolerance loaded at address 2, data bits [11:7].
- R8: If any of R2 to R7 fails, the grade is 0. Otherwise it is 1 plus the smaller of `qual_a` and `qual_b`, saturated at 3.
- R9: A register write takes effect for valid inputs in later cycles. An input presented in the same cycle as the write is still judged with the old value.
- R10: Reset clears `out_vld`, `out_qual` and every configuration field to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Input pair strobe |
| phi_a | input | 12 | Azimuth of the inner segment |
| bend_a | input | 5 | Signed azimuth bend of the inner segment |
| eta_a | input | 7 | Pseudorapidity of the inner segment (also selects the window) |
| qual_a | input | 4 | Quality of the inner segment |
| phi_b | input | 12 | Azimuth of the outer segment |
| bend_b | input | 5 | Signed azimuth bend of the outer segment |
| eta_b | input | 7 | Pseudorapidity of the outer segment |
| qual_b | input | 4 | Quality of the outer segment |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 3 | Configuration register address |
| cfg_data | input | 12 | Configuration write data |
| out_vld | output | 1 | Registered result strobe |
| out_qual | output | 2 | Registered extrapolation grade |

## Verification
The bench builds the block with its default widths: 12-bit azimuth, 5-bit bend, 7-bit pseudorapidity and 4-bit quality. At these widths every pseudorapidity value, every bend code and every quality pair can be swept in full. It walks all 128 inner pseudorapidity values against nearby outer values. It sweeps azimuth differences across the wrap point in each of the four windows, and crosses every bend code with a band of differences around zero. Quality pairs are swept in full. Separate cases cover the all-zero state after reset, idle cycles, and a write that lands in the same cycle as a valid pair.

// File: rtl/seg_pair_pkg.sv
package seg_pair_pkg;
  localparam int PHI_W   = 12;
  localparam int BEND_W  = 5;
  localparam int ETA_W   = 7;
  localparam int QUAL_W  = 4;
  localparam int OQ_W    = 2;
  localparam int CFG_AW  = 3;
  localparam int CFG_DW  = 12;
  localparam int LIM_W   = 6;
  localparam int TOL_W   = 5;
  localparam int N_WIN   = 4;
  localparam int WIN_W   = $clog2(N_WIN);
  localparam int MAG_W   = PHI_W + 1;
  localparam int OQ_MAX  = (1 << OQ_W) - 1;

  localparam int ADR_ETA_MIN = 0;
  localparam int ADR_ETA_MAX = 1;
  localparam int ADR_SPAN    = 2;
  localparam int ADR_THR0    = 3;
  localparam int ADR_LIM0    = 6;
  localparam int LIM_PER_ADR = CFG_DW / LIM_W;

  typedef struct packed {
    logic [ETA_W-1:0]                  eta_min;
    logic [ETA_W-1:0]                  eta_max;
    logic [ETA_W-1:0]                  eta_span;
    logic [TOL_W-1:0]                  bend_tol;
    logic [N_WIN-2:0][ETA_W-1:0]       thr;
    logic [N_WIN-1:0][LIM_W-1:0]       dphi_lim;
  } cfg_t;

  // wrapped signed azimuth difference b - a
  function automatic logic signed [PHI_W-1:0] phi_delta(input logic [PHI_W-1:0] a,
                                                        input logic [PHI_W-1:0] b);
    logic [PHI_W-1:0] r;
    r = b - a;
    return $signed(r);
  endfunction

  function automatic logic [MAG_W-1:0] phi_mag(input logic signed [PHI_W-1:0] d);
    logic [MAG_W-1:0] e;
    e = {d[PHI_W-1], d};
    return d[PHI_W-1] ? (~e + {{PHI_W{1'b0}}, 1'b1}) : e;
  endfunction

  function automatic logic [MAG_W-1:0] bend_mag(input logic signed [BEND_W-1:0] b);
    logic [BEND_W:0] e;
    logic [BEND_W:0] m;
    e = {b[BEND_W-1], b};
    m = b[BEND_W-1] ? (~e + {{BEND_W{1'b0}}, 1'b1}) : e;
    return {{(MAG_W-BEND_W-1){1'b0}}, m};
  endfunction

  function automatic logic [MAG_W-1:0] mag_gap(input logic [MAG_W-1:0] x,
                                               input logic [MAG_W-1:0] y);
    return (x >= y) ? (x - y) : (y - x);
  endfunction

  function automatic logic [ETA_W-1:0] eta_gap(input logic [ETA_W-1:0] x,
                                               input logic [ETA_W-1:0] y);
    return (x >= y) ? (x - y) : (y - x);
  endfunction

  // window index = number of thresholds at or below eta
  function automatic logic [WIN_W-1:0] eta_window(input logic [ETA_W-1:0] eta,
                                                  input logic [N_WIN-2:0][ETA_W-1:0] thr);
    logic [WIN_W-1:0] w;
    w = '0;
    for (int i = 0; i < N_WIN-1; i++)
      if (eta >= thr[i]) w = w + {{(WIN_W-1){1'b0}}, 1'b1};
    return w;
  endfunction

  function automatic logic [OQ_W-1:0] grade_qual(input logic [QUAL_W-1:0] qa,
                                                 input logic [QUAL_W-1:0] qb);
    logic [QUAL_W-1:0] lo;
    lo = (qa < qb) ? qa : qb;
    if (lo >= QUAL_W'(OQ_MAX - 1)) return OQ_W'(OQ_MAX);
    return lo[OQ_W-1:0] + OQ_W'(1);
  endfunction
endpackage

// File: rtl/seg_cfg_regs.sv
module seg_cfg_regs
  import seg_pair_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CFG_AW-1:0] addr,
  input  logic [CFG_DW-1:0] data,
  output cfg_t              cfg
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (we) begin
      if (addr == CFG_AW'(ADR_ETA_MIN)) cfg.eta_min <= data[ETA_W-1:0];
      if (addr == CFG_AW'(ADR_ETA_MAX)) cfg.eta_max <= data[ETA_W-1:0];
      if (addr == CFG_AW'(ADR_SPAN)) begin
        cfg.eta_span <= data[ETA_W-1:0];
        cfg.bend_tol <= data[ETA_W +: TOL_W];
      end
      for (int i = 0; i < N_WIN-1; i++)
        if (addr == CFG_AW'(ADR_THR0 + i)) cfg.thr[i] <= data[ETA_W-1:0];
      for (int i = 0; i < N_WIN; i++)
        if (addr == CFG_AW'(ADR_LIM0 + i / LIM_PER_ADR))
          cfg.dphi_lim[i] <= data[(i % LIM_PER_ADR)*LIM_W +: LIM_W];
    end
  end

  // R9
  cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == CFG_AW'(ADR_ETA_MIN)) |=> (cfg.eta_min == $past(data[ETA_W-1:0])));

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(cfg));
endmodule

// File: rtl/seg_eta_road.sv
module seg_eta_road
  import seg_pair_pkg::*;
(
  input  cfg_t             cfg,
  input  logic [ETA_W-1:0] eta_a,
  input  logic [ETA_W-1:0] eta_b,
  output logic             in_region,
  output logic             span_ok,
  output logic             eta_ok
);
  logic in_a, in_b;

  always_comb begin
    in_a      = (eta_a >= cfg.eta_min) && (eta_a <= cfg.eta_max);
    in_b      = (eta_b >= cfg.eta_min) && (eta_b <= cfg.eta_max);
    in_region = in_a && in_b;
    span_ok   = eta_gap(eta_a, eta_b) <= cfg.eta_span;
    eta_ok    = in_region && span_ok;
  end
endmodule

// File: rtl/seg_phi_road.sv
module seg_phi_road
  import seg_pair_pkg::*;
(
  input  cfg_t                     cfg,
  input  logic [PHI_W-1:0]         phi_a,
  input  logic [PHI_W-1:0]         phi_b,
  input  logic signed [BEND_W-1:0] bend_a,
  input  logic signed [BEND_W-1:0] bend_b,
  input  logic [ETA_W-1:0]         eta_a,
  output logic [WIN_W-1:0]         win,
  output logic                     lim_ok,
  output logic                     sign_ok,
  output logic                     mag_ok,
  output logic                     phi_ok
);
  logic signed [PHI_W-1:0]  dphi;
  logic [MAG_W-1:0]         dmag;
  logic [MAG_W-1:0]         lim_ext;
  logic [MAG_W-1:0]         tol_ext;
  logic [1:0]               st_sign;
  logic [1:0]               st_mag;
  logic signed [BEND_W-1:0] bends [2];

  assign bends[0] = bend_a;
  assign bends[1] = bend_b;

  always_comb begin
    dphi    = phi_delta(phi_a, phi_b);
    dmag    = phi_mag(dphi);
    win     = eta_window(eta_a, cfg.thr);
    lim_ext = {{(MAG_W-LIM_W){1'b0}}, cfg.dphi_lim[win]};
    tol_ext = {{(MAG_W-TOL_W){1'b0}}, cfg.bend_tol};
    lim_ok  = dmag <= lim_ext;
  end

  for (genvar g = 0; g < 2; g++) begin : g_station
    always_comb begin
      st_sign[g] = bends[g][BEND_W-1] == dphi[PHI_W-1];
      st_mag[g]  = mag_gap(dmag, bend_mag(bends[g])) <= tol_ext;
    end
  end

  always_comb begin
    sign_ok = &st_sign;
    mag_ok  = &st_mag;
    phi_ok  = lim_ok && sign_ok && mag_ok;
  end
endmodule

// File: rtl/seg_pair_chk.sv
module seg_pair_chk
  import seg_pair_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_vld,
  input  logic [PHI_W-1:0]         phi_a,
  input  logic signed [BEND_W-1:0] bend_a,
  input  logic [ETA_W-1:0]         eta_a,
  input  logic [QUAL_W-1:0]        qual_a,
  input  logic [PHI_W-1:0]         phi_b,
  input  logic signed [BEND_W-1:0] bend_b,
  input  logic [ETA_W-1:0]         eta_b,
  input  logic [QUAL_W-1:0]        qual_b,
  input  logic                     cfg_we,
  input  logic [CFG_AW-1:0]        cfg_addr,
  input  logic [CFG_DW-1:0]        cfg_data,
  output logic                     out_vld,
  output logic [OQ_W-1:0]          out_qual
);
  cfg_t             cfg;
  logic             in_region, span_ok, eta_ok;
  logic [WIN_W-1:0] win;
  logic             lim_ok, sign_ok, mag_ok, phi_ok;
  logic             road_ok;
  logic [OQ_W-1:0]  qual_next;

  seg_cfg_regs u_cfg (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (cfg_we),
    .addr (cfg_addr),
    .data (cfg_data),
    .cfg  (cfg)
  );

  seg_eta_road u_eta (
    .cfg      (cfg),
    .eta_a    (eta_a),
    .eta_b    (eta_b),
    .in_region(in_region),
    .span_ok  (span_ok),
    .eta_ok   (eta_ok)
  );

  seg_phi_road u_phi (
    .cfg    (cfg),
    .phi_a  (phi_a),
    .phi_b  (phi_b),
    .bend_a (bend_a),
    .bend_b (bend_b),
    .eta_a  (eta_a),
    .win    (win),
    .lim_ok (lim_ok),
    .sign_ok(sign_ok),
    .mag_ok (mag_ok),
    .phi_ok (phi_ok)
  );

  always_comb begin
    road_ok   = eta_ok && phi_ok;
    qual_next = road_ok ? grade_qual(qual_a, qual_b) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld  <= 1'b0;
      out_qual <= '0;
    end else begin
      out_vld  <= in_vld;
      out_qual <= in_vld ? qual_next : '0;
    end
  end

  // R1
  vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld);

  // R1
  vld_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> !out_vld);

  // R1
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_vld |-> (out_qual == '0));

  // R8
  fail_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !(in_region && span_ok && lim_ok && sign_ok && mag_ok)) |=> (out_qual == '0));

  // R8
  pass_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && eta_ok && phi_ok) |=> (out_qual != '0));

  // R5
  win_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eta_a < cfg.thr[0] && eta_a < cfg.thr[1] && eta_a < cfg.thr[2]) |-> (win == '0));
endmodule

// File: tb/seg_pair_chk_bench.sv
`timescale 1ns/1ps
module seg_pair_chk_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_vld = 1'b0;
  logic [11:0] phi_a = '0, phi_b = '0;
  logic signed [4:0] bend_a = '0, bend_b = '0;
  logic [6:0]  eta_a = '0, eta_b = '0;
  logic [3:0]  qual_a = '0, qual_b = '0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [11:0] cfg_data = '0;
  logic        out_vld;
  logic [1:0]  out_qual;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // bench copy of the configuration it has written
  int m_emin = 0, m_emax = 0, m_span = 0, m_tol = 0;
  int m_thr [3] = '{0, 0, 0};
  int m_lim [4] = '{0, 0, 0, 0};

  always #2 clk = ~clk;

  seg_pair_chk u_seg_pair_chk (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld),
    .phi_a(phi_a), .bend_a(bend_a), .eta_a(eta_a), .qual_a(qual_a),
    .phi_b(phi_b), .bend_b(bend_b), .eta_b(eta_b), .qual_b(qual_b),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .out_vld(out_vld), .out_qual(out_qual)
  );

  function automatic int iabs(int v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic int model(int pa, int pb, int ba, int bb, int ea, int eb, int qa, int qb);
    int d, w, lo;
    bit ok;
    d = (pb - pa) % 4096;
    if (d < 0) d += 4096;
    if (d >= 2048) d -= 4096;
    w = 0;
    for (int i = 0; i < 3; i++) if (ea >= m_thr[i]) w++;
    ok = (ea >= m_emin) && (ea <= m_emax) && (eb >= m_emin) && (eb <= m_emax);
    ok = ok && (iabs(eb - ea) <= m_span);
    ok = ok && (iabs(d) <= m_lim[w]);
    ok = ok && ((ba < 0) == (d < 0)) && ((bb < 0) == (d < 0));
    ok = ok && (iabs(iabs(d) - iabs(ba)) <= m_tol) && (iabs(iabs(d) - iabs(bb)) <= m_tol);
    if (!ok) return 0;
    lo = (qa < qb) ? qa : qb;
    return (lo + 1 > 3) ? 3 : lo + 1;
  endfunction

  task automatic chk(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic drive(int pa, int pb, int ba, int bb, int ea, int eb, int qa, int qb);
    phi_a = 12'(pa); phi_b = 12'(pb);
    bend_a = 5'(ba); bend_b = 5'(bb);
    eta_a = 7'(ea); eta_b = 7'(eb);
    qual_a = 4'(qa); qual_b = 4'(qb);
    in_vld = 1'b1;
  endtask

  task automatic apply(int pa, int pb, int ba, int bb, int ea, int eb, int qa, int qb, string tag);
    int e;
    @(negedge clk);
    drive(pa, pb, ba, bb, ea, eb, qa, qb);
    e = model(pa, pb, ba, bb, ea, eb, qa, qb);
    @(negedge clk);
    in_vld = 1'b0;
    chk(out_vld === 1'b1 && out_qual === 2'(e), tag, out_vld ? int'(out_qual) : -1, e);
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'(a); cfg_data = 12'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_span_tol(int span, int tol);
    wr(2, (tol << 7) | span);
    m_span = span; m_tol = tol;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state at the outputs
    chk(out_vld === 1'b0 && out_qual === 2'd0, "R10", int'(out_vld), 0);
    // R10: zero configuration accepts only eta 0 and zero azimuth spread
    apply(300, 300, 0, 0, 0, 0, 2, 2, "R10");
    apply(300, 300, 0, 0, 1, 1, 2, 2, "R10");
    apply(300, 301, 1, 1, 0, 0, 2, 2, "R10");

    wr(0, 10);  m_emin = 10;
    wr(1, 100); m_emax = 100;
    set_span_tol(5, 3);
    wr(3, 30); m_thr[0] = 30;
    wr(4, 60); m_thr[1] = 60;
    wr(5, 90); m_thr[2] = 90;
    wr(6, (16 << 6) | 8);  m_lim[0] = 8;  m_lim[1] = 16;
    wr(7, (32 << 6) | 24); m_lim[2] = 24; m_lim[3] = 32;

    // R1: idle cycles give no strobe and a zero grade
    @(negedge clk);
    drive(500, 500, 0, 0, 50, 50, 3, 3);
    in_vld = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(out_vld === 1'b0 && out_qual === 2'd0, "R1", int'(out_qual), 0);
    end

    // R2 R3: region and span sweep
    for (int ea = 0; ea < 128; ea++)
      for (int k = -7; k <= 7; k++)
        if (ea + k >= 0 && ea + k < 128)
          apply(500, 500, 0, 0, ea, ea + k, 1, 1, "R2 R3");

    // R4 R5: azimuth limit per window, across the wrap point
    set_span_tol(5, 31);
    foreach (m_lim[w]) begin
      int ea;
      ea = (w == 0) ? 20 : (w == 1) ? 35 : (w == 2) ? 65 : 95;
      for (int d = -40; d <= 40; d++) begin
        int b;
        b = (d < -16) ? -16 : (d > 15) ? 15 : d;
        apply(4090, (4090 + d) & 4095, b, b, ea, ea, 1, 0, "R4 R5");
      end
    end

    // R6 R7: bend sign and magnitude against the azimuth difference
    set_span_tol(5, 3);
    for (int d = -20; d <= 20; d++)
      for (int ba = -16; ba <= 15; ba++)
        for (int j = 0; j < 4; j++) begin
          int bb;
          bb = (j == 0) ? -5 : (j == 1) ? 0 : (j == 2) ? 3 : ((d < -16) ? -16 : (d > 15) ? 15 : d);
          apply(2000, 2000 + d, ba, bb, 95, 95, 2, 1, "R6 R7");
        end

    // R8: grading over all quality pairs on a passing geometry
    for (int qa = 0; qa < 16; qa++)
      for (int qb = 0; qb < 16; qb++)
        apply(700, 702, 2, 1, 50, 52, qa, qb, "R8");

    // R9: a write in the same cycle as a valid pair is not yet seen
    @(negedge clk);
    drive(800, 800, 0, 0, 80, 80, 1, 1);
    cfg_we = 1'b1; cfg_addr = 3'd1; cfg_data = 12'd50;
    @(negedge clk);
    in_vld = 1'b0; cfg_we = 1'b0;
    chk(out_vld === 1'b1 && out_qual === 2'd2, "R9", int'(out_qual), 2);
    m_emax = 50;
    apply(800, 800, 0, 0, 80, 80, 1, 1, "R9");
    apply(800, 800, 0, 0, 50, 50, 1, 1, "R9");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule